// File: doc/BRIEF.md
# Instruction Line Request Unit

This unit sits in a multithreaded fetch stage, between the per-thread program counters and the instruction cache. Each cycle it may take one fetch request: a thread number, a byte address and a per-word predicted-taken mask for the line that holds the address. It rounds the address down to a cache-block boundary and looks in that thread's one-line buffer. On a hit it returns, one cycle later, a lane-packed group of instruction words and a count. On a miss it sends a block read to the cache.

The cache may refuse a read. A refused read is parked in one retry slot shared by all threads. While the slot is in use, no thread may start a new read. When the cache signals retry, the parked read is sent again. If the owning thread is squashed first, the parked read is dropped. Each thread can have one read in flight, and each read carries a small per-thread tag. A full-line response fills the buffer only if its tag matches the thread's latest read and the thread is still waiting for it.

Top module: `iline_fetch_unit`

## Requirements
- R1: Every block read leaves with its address equal to the fetch address with the low log2(BLK_BYTES) bits cleared.
- R2: A fetch to an idle thread whose buffer is valid and whose stored tag equals the aligned address issues no read. It raises out_valid one cycle later with that thread's number. The block-blocked condition does not stop such a hit.
- R3: Issuing a read stores the aligned address as the thread's new tag and marks the buffer invalid. From then until a matching response arrives, a fetch to that thread produces neither output nor read.
- R4: A read that is refused (mem_req_ready low while mem_req_valid is high) is held in the shared retry slot together with its thread number, and the cache-blocked state is set.
- R5: While the cache-blocked state is set, no thread starts a new read. A fetch that misses in that state produces no read and no output.
- R6: A mem_retry pulse while the slot holds a read presents that read again, with the same address, thread and tag. If it is accepted, the slot empties, the blocked state clears, and the thread waits for its response.
- R7: A mem_retry pulse while the slot is empty presents no read and only clears the blocked state. After that, new reads may be issued.
- R8: squash_valid for the thread that owns the slot empties the slot. A squash also ends any wait of that thread for a response.
- R9: Output lane i (out_words bits [32i+31:32i]) holds line word (s+i), where s = fetch_addr[3:2] with default sizes. Word j of a line is data bits [32j+31:32j], and it is flagged taken by fetch_taken[j]. Extraction stops at FETCH_W words, at the end of the line, or just after the first flagged word. out_count gives the number of lanes filled.
- R10: A response whose tag differs from the thread's latest read tag, or which arrives after a squash, is dropped and leaves the buffer unfilled.
- R11: After reset, out_valid and mem_req_valid are low, out_count is zero and the blocked state is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_tid | input | TID_W | Requesting thread |
| fetch_addr | input | ADDR_W | Byte fetch address |
| fetch_taken | input | WPL | Predicted-taken flag per word of the line |
| squash_valid | input | 1 | Squash a thread this cycle |
| squash_tid | input | TID_W | Thread being squashed |
| mem_req_valid | output | 1 | Block read presented to the cache |
| mem_req_addr | output | ADDR_W | Block-aligned read address |
| mem_req_tid | output | TID_W | Thread of the read |
| mem_req_id | output | ID_W | Per-thread read tag |
| mem_req_ready | input | 1 | Cache accepts the read this cycle |
| mem_retry | input | 1 | Cache can now take a refused read |
| mem_rsp_valid | input | 1 | Line response present |
| mem_rsp_tid | input | TID_W | Thread of the response |
| mem_rsp_id | input | ID_W | Tag of the response |
| mem_rsp_data | input | LINE_W | Full line of data |
| out_valid | output | 1 | Extracted words valid |
| out_tid | output | TID_W | Thread of the extracted words |
| out_words | output | FETCH_W*WORD_W | Lane-packed instruction words |
| out_count | output | CNT_W | Number of lanes filled |

## Verification
The assertions assume the cache raises mem_retry only while the unit reports itself blocked. They also assume mem_req_ready is meaningful only in a cycle where a read is presented, and that the squash thread number is in range. The stimulus respects these assumptions. Retry pulses are driven only after a refusal, and mem_req_ready is held high except for the single cycle of a planned refusal. Responses carry only tags that the unit actually issued. Stale and mismatched responses are produced on purpose by squashing a thread and re-issuing a read before the old tag returns.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic [1:0] {
    TS_IDLE       = 2'd0,
    TS_WAIT_RSP   = 2'd1,
    TS_WAIT_RETRY = 2'd2
  } thr_state_e;
endpackage

// File: rtl/ifu_line_buf.sv
module ifu_line_buf #(
  parameter int NTHR   = 2,
  parameter int ADDR_W = 16,
  parameter int LINE_W = 128,
  parameter int TID_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TID_W-1:0]  rd_tid,
  input  logic [ADDR_W-1:0] rd_tag,
  output logic              hit,
  output logic [LINE_W-1:0] rd_line,
  input  logic              alloc,
  input  logic [TID_W-1:0]  alloc_tid,
  input  logic [ADDR_W-1:0] alloc_tag,
  input  logic              fill,
  input  logic [TID_W-1:0]  fill_tid,
  input  logic [LINE_W-1:0] fill_data
);
  logic [LINE_W-1:0] mem   [NTHR];
  logic [ADDR_W-1:0] tag_q [NTHR];
  logic              vld_q [NTHR];

  // data store: no reset so that it maps onto RAM
  always_ff @(posedge clk) begin
    if (fill) mem[fill_tid] <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTHR; t++) begin
        tag_q[t] <= '0;
        vld_q[t] <= 1'b0;
      end
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        if (alloc && alloc_tid == TID_W'(t)) begin
          tag_q[t] <= alloc_tag;
          vld_q[t] <= 1'b0;
        end else if (fill && fill_tid == TID_W'(t)) begin
          vld_q[t] <= 1'b1;
        end
      end
    end
  end

  assign hit     = vld_q[rd_tid] && (tag_q[rd_tid] == rd_tag);
  assign rd_line = mem[rd_tid];
endmodule

// File: rtl/ifu_retry_slot.sv
module ifu_retry_slot #(
  parameter int ADDR_W = 16,
  parameter int TID_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [TID_W-1:0]  cap_tid,
  input  logic              retry,
  input  logic              resend_ok,
  input  logic              kill,
  output logic              blocked,
  output logic              slot_valid,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [TID_W-1:0]  slot_tid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      blocked    <= 1'b0;
      slot_valid <= 1'b0;
      slot_addr  <= '0;
      slot_tid   <= '0;
    end else if (capture) begin
      blocked    <= 1'b1;
      slot_valid <= 1'b1;
      slot_addr  <= cap_addr;
      slot_tid   <= cap_tid;
    end else begin
      if (kill) slot_valid <= 1'b0;
      if (blocked && retry && (!slot_valid || kill)) blocked <= 1'b0;
      if (resend_ok) begin
        slot_valid <= 1'b0;
        blocked    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ifu_extract.sv
module ifu_extract #(
  parameter int WORD_W  = 32,
  parameter int WPL     = 4,
  parameter int FETCH_W = 3,
  parameter int WIDX_W  = 2,
  parameter int CNT_W   = 2
) (
  input  logic [WORD_W*WPL-1:0]     line,
  input  logic [WIDX_W-1:0]         start,
  input  logic [WPL-1:0]            taken,
  output logic [FETCH_W*WORD_W-1:0] words,
  output logic [CNT_W-1:0]          count
);
  logic stop;
  int   idx;

  always_comb begin
    words = '0;
    count = '0;
    stop  = 1'b0;
    idx   = 0;
    for (int i = 0; i < FETCH_W; i++) begin
      idx = int'(start) + i;
      if (!stop && idx < WPL) begin
        words[i*WORD_W +: WORD_W] = line[idx*WORD_W +: WORD_W];
        count = count + CNT_W'(1);
        if (taken[idx]) stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iline_fetch_unit.sv
module iline_fetch_unit
  import ifu_pkg::*;
#(
  parameter int NTHR       = 2,
  parameter int ADDR_W     = 16,
  parameter int BLK_BYTES  = 16,
  parameter int WORD_BYTES = 4,
  parameter int FETCH_W    = 3,
  parameter int ID_W       = 2,
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int WORD_W = 8 * WORD_BYTES,
  localparam int WPL    = BLK_BYTES / WORD_BYTES,
  localparam int LINE_W = 8 * BLK_BYTES,
  localparam int CNT_W  = $clog2(FETCH_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fetch_valid,
  input  logic [TID_W-1:0]          fetch_tid,
  input  logic [ADDR_W-1:0]         fetch_addr,
  input  logic [WPL-1:0]            fetch_taken,
  input  logic                      squash_valid,
  input  logic [TID_W-1:0]          squash_tid,
  output logic                      mem_req_valid,
  output logic [ADDR_W-1:0]         mem_req_addr,
  output logic [TID_W-1:0]          mem_req_tid,
  output logic [ID_W-1:0]           mem_req_id,
  input  logic                      mem_req_ready,
  input  logic                      mem_retry,
  input  logic                      mem_rsp_valid,
  input  logic [TID_W-1:0]          mem_rsp_tid,
  input  logic [ID_W-1:0]           mem_rsp_id,
  input  logic [LINE_W-1:0]         mem_rsp_data,
  output logic                      out_valid,
  output logic [TID_W-1:0]          out_tid,
  output logic [FETCH_W*WORD_W-1:0] out_words,
  output logic [CNT_W-1:0]          out_count
);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int WB_W   = $clog2(WORD_BYTES);
  localparam int WIDX_W = (WPL > 1) ? $clog2(WPL) : 1;

  thr_state_e    thr_q [NTHR];
  logic [ID_W-1:0] id_q [NTHR];

  logic [ADDR_W-1:0] aligned;
  logic [WIDX_W-1:0] start_idx;
  logic              lb_hit;
  logic [LINE_W-1:0] lb_line;
  logic              blocked, slot_valid;
  logic [ADDR_W-1:0] slot_addr;
  logic [TID_W-1:0]  slot_tid;
  logic              fetch_ok, do_hit, new_req, slot_kill;
  logic              resend, resend_ok, rsp_ok;
  logic [FETCH_W*WORD_W-1:0] ex_words;
  logic [CNT_W-1:0]          ex_count;

  assign aligned   = fetch_addr & ~ADDR_W'(BLK_BYTES - 1);
  assign start_idx = WIDX_W'(fetch_addr[OFF_W-1:0] >> WB_W);

  always_comb begin
    fetch_ok  = fetch_valid && !(squash_valid && squash_tid == fetch_tid)
                && thr_q[fetch_tid] == TS_IDLE;
    do_hit    = fetch_ok && lb_hit;
    new_req   = fetch_ok && !lb_hit && !blocked;
    slot_kill = squash_valid && squash_tid == slot_tid;
    resend    = blocked && mem_retry && slot_valid && !slot_kill;
    resend_ok = resend && mem_req_ready;
    rsp_ok    = mem_rsp_valid && thr_q[mem_rsp_tid] == TS_WAIT_RSP
                && mem_rsp_id == id_q[mem_rsp_tid]
                && !(squash_valid && squash_tid == mem_rsp_tid);
  end

  assign mem_req_valid = new_req || resend;
  assign mem_req_addr  = resend ? slot_addr : aligned;
  assign mem_req_tid   = resend ? slot_tid : fetch_tid;
  assign mem_req_id    = resend ? id_q[slot_tid] : id_q[fetch_tid] + ID_W'(1);

  ifu_line_buf #(
    .NTHR(NTHR), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .TID_W(TID_W)
  ) u_lbuf (
    .clk(clk), .rst(rst),
    .rd_tid(fetch_tid), .rd_tag(aligned), .hit(lb_hit), .rd_line(lb_line),
    .alloc(new_req), .alloc_tid(fetch_tid), .alloc_tag(aligned),
    .fill(rsp_ok), .fill_tid(mem_rsp_tid), .fill_data(mem_rsp_data)
  );

  ifu_retry_slot #(.ADDR_W(ADDR_W), .TID_W(TID_W)) u_slot (
    .clk(clk), .rst(rst),
    .capture(new_req && !mem_req_ready), .cap_addr(aligned), .cap_tid(fetch_tid),
    .retry(mem_retry), .resend_ok(resend_ok), .kill(slot_kill),
    .blocked(blocked), .slot_valid(slot_valid), .slot_addr(slot_addr),
    .slot_tid(slot_tid)
  );

  ifu_extract #(
    .WORD_W(WORD_W), .WPL(WPL), .FETCH_W(FETCH_W), .WIDX_W(WIDX_W), .CNT_W(CNT_W)
  ) u_ext (
    .line(lb_line), .start(start_idx), .taken(fetch_taken),
    .words(ex_words), .count(ex_count)
  );

  // per-thread request state and tags
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTHR; t++) begin
        thr_q[t] <= TS_IDLE;
        id_q[t]  <= '0;
      end
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        if (new_req && fetch_tid == TID_W'(t)) id_q[t] <= id_q[t] + ID_W'(1);
        if (squash_valid && squash_tid == TID_W'(t))
          thr_q[t] <= TS_IDLE;
        else if (new_req && fetch_tid == TID_W'(t))
          thr_q[t] <= mem_req_ready ? TS_WAIT_RSP : TS_WAIT_RETRY;
        else if (resend_ok && slot_tid == TID_W'(t))
          thr_q[t] <= TS_WAIT_RSP;
        else if (rsp_ok && mem_rsp_tid == TID_W'(t))
          thr_q[t] <= TS_IDLE;
      end
    end
  end

  // registered output group
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tid   <= '0;
      out_words <= '0;
      out_count <= '0;
    end else begin
      out_valid <= do_hit;
      if (do_hit) begin
        out_tid   <= fetch_tid;
        out_words <= ex_words;
        out_count <= ex_count;
      end
    end
  end
endmodule

// File: rtl/ifu_checker.sv
module ifu_checker #(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 16,
  parameter int FETCH_W   = 3,
  parameter int TID_W     = 1,
  localparam int OFF_W = $clog2(BLK_BYTES),
  localparam int CNT_W = $clog2(FETCH_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_ready,
  input logic              mem_retry,
  input logic              squash_valid,
  input logic [TID_W-1:0]  squash_tid,
  input logic              out_valid,
  input logic [CNT_W-1:0]  out_count,
  input logic              blocked,
  input logic              slot_valid,
  input logic [TID_W-1:0]  slot_tid
);
  assert_req_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  assert_reject_parks_R4: assert property (@(posedge clk) disable iff (rst)
    (!blocked && mem_req_valid && !mem_req_ready) |=> (blocked && slot_valid));

  assert_blocked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (blocked && mem_req_valid) |-> (mem_retry && slot_valid));

  assert_resend_unblocks_R6: assert property (@(posedge clk) disable iff (rst)
    (blocked && mem_req_valid && mem_req_ready) |=> (!blocked && !slot_valid));

  assert_empty_retry_R7: assert property (@(posedge clk) disable iff (rst)
    (blocked && mem_retry && !slot_valid) |=> !blocked);

  assert_squash_slot_R8: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && squash_valid && squash_tid == slot_tid) |=> !slot_valid);

  assert_count_range_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count != '0 && out_count <= CNT_W'(FETCH_W)));
endmodule

bind iline_fetch_unit ifu_checker #(
  .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .FETCH_W(FETCH_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst(rst), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_req_ready(mem_req_ready), .mem_retry(mem_retry),
  .squash_valid(squash_valid), .squash_tid(squash_tid),
  .out_valid(out_valid), .out_count(out_count),
  .blocked(blocked), .slot_valid(slot_valid), .slot_tid(slot_tid)
);

// File: tb/iline_fetch_unit_tb.sv
module iline_fetch_unit_tb;
  localparam int AW = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fetch_valid = 1'b0;
  logic [0:0]   fetch_tid = '0;
  logic [AW-1:0] fetch_addr = '0;
  logic [3:0]   fetch_taken = '0;
  logic         squash_valid = 1'b0;
  logic [0:0]   squash_tid = '0;
  logic         mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic [0:0]   mem_req_tid;
  logic [1:0]   mem_req_id;
  logic         mem_req_ready = 1'b1;
  logic         mem_retry = 1'b0;
  logic         mem_rsp_valid = 1'b0;
  logic [0:0]   mem_rsp_tid = '0;
  logic [1:0]   mem_rsp_id = '0;
  logic [127:0] mem_rsp_data = '0;
  logic         out_valid;
  logic [0:0]   out_tid;
  logic [95:0]  out_words;
  logic [1:0]   out_count;

  iline_fetch_unit #(
    .NTHR(2), .ADDR_W(AW), .BLK_BYTES(16), .WORD_BYTES(4), .FETCH_W(3), .ID_W(2)
  ) u_dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    int          tid;
    int          cnt;
    logic [95:0] words;
    string       rq;
  } exp_t;

  exp_t         sb[$];
  logic [127:0] model [2];
  int           checks = 0;
  int           errors = 0;
  logic [1:0]   last_id;

  task automatic chk(string rq, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mkline(int tid, logic [15:0] base);
    logic [127:0] l;
    for (int j = 0; j < 4; j++) l[32*j +: 32] = {8'(tid + 1), base, 8'(j)};
    return l;
  endfunction

  function automatic exp_t mkexp(int tid, logic [15:0] addr, logic [3:0] taken, string rq);
    exp_t e;
    int   s;
    e.tid = tid; e.cnt = 0; e.words = '0; e.rq = rq;
    s = int'(addr[3:2]);
    for (int i = 0; i < 3; i++) begin
      if (s + i > 3) break;
      e.words[32*i +: 32] = model[tid][32*(s+i) +: 32];
      e.cnt++;
      if (taken[s+i]) break;
    end
    return e;
  endfunction

  task automatic do_fetch(int tid, logic [15:0] addr, logic [3:0] taken,
                          bit exp_out, bit exp_req, logic [15:0] exp_addr, string rq);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_tid = tid[0]; fetch_addr = addr; fetch_taken = taken;
    #1;
    chk(rq, "req_valid", mem_req_valid, exp_req);
    if (exp_req) begin
      chk(rq, "req_addr", mem_req_addr, exp_addr);
      chk(rq, "req_tid", mem_req_tid, tid);
      last_id = mem_req_id;
    end
    if (exp_out) sb.push_back(mkexp(tid, addr, taken, rq));
    @(negedge clk);
    fetch_valid = 1'b0;
    if (!exp_out) chk(rq, "no_output", out_valid, 0);
  endtask

  task automatic respond(int tid, logic [1:0] id, logic [15:0] base, bit accept);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_tid = tid[0]; mem_rsp_id = id;
    mem_rsp_data = mkline(tid, base);
    if (accept) model[tid] = mkline(tid, base);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic retry_pulse(bit exp_req, logic [15:0] exp_addr, int exp_tid, string rq);
    @(negedge clk);
    mem_retry = 1'b1;
    #1;
    chk(rq, "retry_req_valid", mem_req_valid, exp_req);
    if (exp_req) begin
      chk(rq, "retry_addr", mem_req_addr, exp_addr);
      chk(rq, "retry_tid", mem_req_tid, exp_tid);
      last_id = mem_req_id;
    end
    @(negedge clk);
    mem_retry = 1'b0;
  endtask

  task automatic squash(int tid);
    @(negedge clk);
    squash_valid = 1'b1; squash_tid = tid[0];
    @(negedge clk);
    squash_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever the unit presents words
  always @(negedge clk) begin
    exp_t e;
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected output actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        chk(e.rq, "out_tid", out_tid, e.tid);
        chk(e.rq, "out_count", out_count, e.cnt);
        for (int i = 0; i < e.cnt; i++)
          chk(e.rq, "out_word", out_words[32*i +: 32], e.words[32*i +: 32]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] id_a, id_b;
    model[0] = '0; model[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11", "out_valid", out_valid, 0);
    chk("R11", "req_valid", mem_req_valid, 0);
    chk("R11", "out_count", out_count, 0);

    // miss, align, wait, fill, hits with several stop reasons
    do_fetch(0, 16'h0104, 4'b0000, 0, 1, 16'h0100, "R1");
    id_a = last_id;
    do_fetch(0, 16'h0104, 4'b0000, 0, 0, 16'h0, "R3");
    respond(0, id_a, 16'h0100, 1);
    do_fetch(0, 16'h0104, 4'b0000, 1, 0, 16'h0, "R2");
    do_fetch(0, 16'h0108, 4'b0000, 1, 0, 16'h0, "R9");
    do_fetch(0, 16'h0100, 4'b0010, 1, 0, 16'h0, "R9");
    do_fetch(0, 16'h0100, 4'b0000, 1, 0, 16'h0, "R9");
    do_fetch(0, 16'h010C, 4'b1000, 1, 0, 16'h0, "R9");

    // refusal, blocked, retry resend
    mem_req_ready = 1'b0;
    do_fetch(1, 16'h0208, 4'b0000, 0, 1, 16'h0200, "R4");
    mem_req_ready = 1'b1;
    do_fetch(0, 16'h0304, 4'b0000, 0, 0, 16'h0, "R5");
    do_fetch(0, 16'h0104, 4'b0000, 1, 0, 16'h0, "R2");
    retry_pulse(1, 16'h0200, 1, "R6");
    respond(1, last_id, 16'h0200, 1);
    do_fetch(1, 16'h0208, 4'b0000, 1, 0, 16'h0, "R6");

    // squash of slot owner, then retry with empty slot
    mem_req_ready = 1'b0;
    do_fetch(1, 16'h0404, 4'b0000, 0, 1, 16'h0400, "R4");
    mem_req_ready = 1'b1;
    squash(1);
    retry_pulse(0, 16'h0, 0, "R8");
    do_fetch(0, 16'h0304, 4'b0000, 0, 1, 16'h0300, "R7");
    respond(0, last_id, 16'h0300, 1);
    do_fetch(0, 16'h0300, 4'b0000, 1, 0, 16'h0, "R7");

    // stale tag after squash
    do_fetch(1, 16'h0504, 4'b0000, 0, 1, 16'h0500, "R10");
    id_a = last_id;
    squash(1);
    do_fetch(1, 16'h0604, 4'b0000, 0, 1, 16'h0600, "R10");
    id_b = last_id;
    chk("R10", "fresh_tag_differs", (id_a != id_b), 1);
    respond(1, id_a, 16'h0500, 0);
    do_fetch(1, 16'h0604, 4'b0000, 0, 0, 16'h0, "R10");
    respond(1, id_b, 16'h0600, 1);
    do_fetch(1, 16'h0604, 4'b0100, 1, 0, 16'h0, "R10");

    // issuing a read replaces the tag and invalidates the buffer
    do_fetch(0, 16'h0700, 4'b0000, 0, 1, 16'h0700, "R3");
    id_a = last_id;
    do_fetch(0, 16'h0300, 4'b0000, 0, 0, 16'h0, "R3");
    respond(0, id_a, 16'h0700, 1);
    do_fetch(0, 16'h0300, 4'b0000, 0, 1, 16'h0300, "R3");
    respond(0, last_id, 16'h0300, 1);
    do_fetch(0, 16'h0308, 4'b0000, 1, 0, 16'h0, "R3");

    repeat (3) @(negedge clk);
    chk("R9", "scoreboard_empty", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule